// File: doc/BRIEF.md
# Three-Class Interrupt Entry Controller

This block sits next to a small processor core and decides, on every clock, whether to take an interrupt. Requests come in three classes: machine check, critical and noncritical. A watchdog timeout counts as a critical request. Each class is gated by its own enable bit in a state word that the block holds. When several unmasked classes are pending, a fixed priority picks one.

Taking an interrupt does four things. The core's current program counter and the state word (as it stood before the take) are copied into that class's own save pair. The enable of the taken class and the enables of every lower class are cleared. A one-cycle redirect to the class vector is issued. The class is marked as holding a saved context.

Each class has its own return strobe. A return puts the state word back from that class's pair and redirects the core to the saved address. Because the three pairs are separate, a critical or machine check handler can run inside a noncritical handler without disturbing the outer saved context.

Top module: `irq_entry_ctrl`

## Requirements
- R1: With several unmasked requests pending in the same cycle, only one is taken. Machine check beats critical, and critical beats noncritical.
- R2: The redirect output pulses valid for exactly one cycle, in the cycle after the clock edge that takes the interrupt. Its address is 0x100 for machine check, 0x200 for critical and 0x300 for noncritical.
- R3: Machine check is enabled by state-word bit 2, critical by bit 1 and noncritical by bit 0. A request whose enable bit is 0 is not taken and leaves the state word unchanged.
- R4: A take stores the current program counter and the pre-take state word in the taken class's save pair.
- R5: A take clears the enable bit of the taken class and of every lower-priority class. Higher-priority enables and all other state-word bits keep their values.
- R6: A critical take during a noncritical handler leaves the noncritical save pair intact. The two returns then restore each context in turn.
- R7: A watchdog timeout is taken as a critical request, with vector 0x200.
- R8: A return strobe for a class that holds a saved context restores the state word from that class's pair. It also issues a one-cycle redirect to the saved program counter and releases the context.
- R9: A return strobe for a class with no saved context is ignored: no redirect is issued and the state word is unchanged.
- R10: After reset the state word is 0, no redirect is issued and no class holds a saved context.
- R11: If a valid return and an unmasked request fall in the same cycle, the return is performed and no interrupt is taken in that cycle. A request still pending is then judged against the restored state word in the next cycle.
- R12: A software write to the state word takes effect only in a cycle with neither a take nor a return. In a cycle with a take or a return, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_mchk_i | input | 1 | Machine check request level |
| req_crit_i | input | 1 | Critical request level |
| req_ncrit_i | input | 1 | Noncritical (external) request level |
| wdog_tmo_i | input | 1 | Watchdog timeout, critical class |
| pc_i | input | AW | Current program counter of the core |
| sw_we_i | input | 1 | Software write strobe for the state word |
| sw_wdata_i | input | SW | Write data for the state word |
| ret_mchk_i | input | 1 | Machine check return strobe |
| ret_crit_i | input | 1 | Critical return strobe |
| ret_ncrit_i | input | 1 | Noncritical return strobe |
| sw_o | output | SW | Current state word |
| redir_vld_o | output | 1 | Redirect valid, one-cycle pulse |
| redir_addr_o | output | AW | Redirect target: vector or restored address |

## Verification
Two things can land in the same cycle: a valid return for one class and a fresh unmasked request for another. The bench provokes this by returning from a noncritical handler while a critical request is held high. It then expects the redirect to the saved noncritical address, with the restored state word, in that cycle. The critical vector is expected one cycle later. A second collision pairs a software write of the state word with a take, and the bench expects the write to be lost and the take's clearing to be the visible result.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NCLS   = 3;
  localparam int CLS_MC = 0;
  localparam int CLS_CR = 1;
  localparam int CLS_NC = 2;

  // lowest index wins: index order is priority order
  function automatic logic [NCLS-1:0] pick_first(input logic [NCLS-1:0] v);
    logic [NCLS-1:0] r;
    r = '0;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NCLS-1:0] req,
  input  logic [NCLS-1:0] en,
  input  logic [NCLS-1:0] ret,
  input  logic [NCLS-1:0] ctx_vld,
  output logic [NCLS-1:0] take_oh,
  output logic [NCLS-1:0] ret_oh
);
  logic [NCLS-1:0] ret_ok;
  logic [NCLS-1:0] pend;

  always_comb begin
    ret_ok = ret & ctx_vld;
    pend   = req & en;
    ret_oh = pick_first(ret_ok);
    // a valid return owns the cycle
    take_oh = (|ret_ok) ? '0 : pick_first(pend);
  end
endmodule

// File: rtl/irq_save_slot.sv
module irq_save_slot #(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          rel_en,
  input  logic [AW-1:0] pc_in,
  input  logic [SW-1:0] sw_in,
  output logic [AW-1:0] pc_q,
  output logic [SW-1:0] sw_q,
  output logic          vld_q
);
  logic vld_d;

  always_comb begin
    vld_d = vld_q;
    if (cap_en)      vld_d = 1'b1;
    else if (rel_en) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sw_q <= '0;
    end else if (cap_en) begin
      pc_q <= pc_in;
      sw_q <= sw_in;
    end
  end

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (pc_q == $past(pc_in)) && (sw_q == $past(sw_in)) && vld_q);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !cap_en) |=> !vld_q);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          SW       = 32,
  parameter int          ME_BIT   = 2,
  parameter int          CE_BIT   = 1,
  parameter int          EE_BIT   = 0,
  parameter logic [31:0] VEC_BASE = 32'h100,
  parameter logic [31:0] VEC_STEP = 32'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_mchk_i,
  input  logic          req_crit_i,
  input  logic          req_ncrit_i,
  input  logic          wdog_tmo_i,
  input  logic [AW-1:0] pc_i,
  input  logic          sw_we_i,
  input  logic [SW-1:0] sw_wdata_i,
  input  logic          ret_mchk_i,
  input  logic          ret_crit_i,
  input  logic          ret_ncrit_i,
  output logic [SW-1:0] sw_o,
  output logic          redir_vld_o,
  output logic [AW-1:0] redir_addr_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  function automatic int en_pos(input int cls);
    case (cls)
      CLS_MC:  return ME_BIT;
      CLS_CR:  return CE_BIT;
      default: return EE_BIT;
    endcase
  endfunction

  logic [SW-1:0]   sw_q, sw_d;
  logic            redir_vld_q, redir_vld_d;
  logic [AW-1:0]   redir_addr_q, redir_addr_d;
  logic [NCLS-1:0] req_v, en_v, ret_v;
  logic [NCLS-1:0] take_oh, ret_oh, ctx_vld;
  logic [AW-1:0]   slot_pc [NCLS];
  logic [SW-1:0]   slot_sw [NCLS];
  logic [SW-1:0]   clr_mask;
  logic [AW-1:0]   vec_sel, ret_pc;
  logic [SW-1:0]   ret_sw;

  always_comb begin
    req_v = '0;
    en_v  = '0;
    ret_v = '0;
    req_v[CLS_MC] = req_mchk_i;
    req_v[CLS_CR] = req_crit_i | wdog_tmo_i;
    req_v[CLS_NC] = req_ncrit_i;
    ret_v[CLS_MC] = ret_mchk_i;
    ret_v[CLS_CR] = ret_crit_i;
    ret_v[CLS_NC] = ret_ncrit_i;
    for (int k = 0; k < NCLS; k++) en_v[k] = sw_q[en_pos(k)];
  end

  irq_arbiter u_arb (
    .req     (req_v),
    .en      (en_v),
    .ret     (ret_v),
    .ctx_vld (ctx_vld),
    .take_oh (take_oh),
    .ret_oh  (ret_oh)
  );

  for (genvar g = 0; g < NCLS; g++) begin : g_slot
    irq_save_slot #(.AW(AW), .SW(SW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_ns),
      .cap_en (take_oh[g]),
      .rel_en (ret_oh[g]),
      .pc_in  (pc_i),
      .sw_in  (sw_q),
      .pc_q   (slot_pc[g]),
      .sw_q   (slot_sw[g]),
      .vld_q  (ctx_vld[g])
    );
  end

  // which enables to drop, what vector to issue, what to restore
  always_comb begin
    clr_mask = '0;
    vec_sel  = '0;
    ret_pc   = '0;
    ret_sw   = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (take_oh[k]) begin
        vec_sel = AW'(VEC_BASE + VEC_STEP * 32'(k));
        for (int j = 0; j < NCLS; j++)
          if (j >= k) clr_mask[en_pos(j)] = 1'b1;
      end
      if (ret_oh[k]) begin
        ret_pc = slot_pc[k];
        ret_sw = slot_sw[k];
      end
    end
  end

  always_comb begin
    sw_d         = sw_q;
    redir_vld_d  = 1'b0;
    redir_addr_d = redir_addr_q;
    if (|ret_oh) begin
      sw_d         = ret_sw;
      redir_vld_d  = 1'b1;
      redir_addr_d = ret_pc;
    end else if (|take_oh) begin
      sw_d         = sw_q & ~clr_mask;
      redir_vld_d  = 1'b1;
      redir_addr_d = vec_sel;
    end else if (sw_we_i) begin
      sw_d = sw_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sw_q         <= '0;
      redir_vld_q  <= 1'b0;
      redir_addr_q <= '0;
    end else begin
      sw_q        <= sw_d;
      redir_vld_q <= redir_vld_d;
      if (redir_vld_d) redir_addr_q <= redir_addr_d;
    end
  end

  assign sw_o         = sw_q;
  assign redir_vld_o  = redir_vld_q;
  assign redir_addr_o = redir_addr_q;

  for (genvar g = 0; g < NCLS; g++) begin : g_vec_chk
    a_r2_vector: assert property (@(posedge clk) disable iff (!rst_ns)
      take_oh[g] |=> redir_vld_o && (redir_addr_o == AW'(VEC_BASE + VEC_STEP * 32'(g))));
  end

  a_r5_lower_clear: assert property (@(posedge clk) disable iff (!rst_ns)
    take_oh[CLS_NC] |=> !sw_q[EE_BIT] && (sw_q[ME_BIT] == $past(sw_q[ME_BIT]))
                        && (sw_q[CE_BIT] == $past(sw_q[CE_BIT])));

  a_r8_restore: assert property (@(posedge clk) disable iff (!rst_ns)
    (|ret_oh) |=> (sw_q == $past(ret_sw)) && (redir_addr_o == $past(ret_pc)) && redir_vld_o);

  a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_ns)
    ((ret_v != '0) && ((ret_v & ctx_vld) == '0) && ((req_v & en_v) == '0) && !sw_we_i)
      |=> !redir_vld_o && (sw_q == $past(sw_q)));

  a_r11_ret_first: assert property (@(posedge clk) disable iff (!rst_ns)
    (ret_ncrit_i && ctx_vld[CLS_NC] && !ret_mchk_i && !ret_crit_i)
      |=> redir_addr_o == $past(slot_pc[CLS_NC]));
endmodule

// File: tb/tb_irq_entry_ctrl.sv
`timescale 1ns/1ps
module tb_irq_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_mchk, req_crit, req_ncrit, wdog;
  logic [31:0] pc;
  logic        sw_we;
  logic [31:0] sw_wdata;
  logic        ret_mchk, ret_crit, ret_ncrit;
  logic [31:0] sw;
  logic        redir_vld;
  logic [31:0] redir_addr;

  int          n_chk  = 0;
  int          n_fail = 0;
  bit          mon_on = 1'b0;
  bit          done   = 1'b0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  irq_entry_ctrl dut (
    .clk (clk), .rst_n (rst_n),
    .req_mchk_i (req_mchk), .req_crit_i (req_crit), .req_ncrit_i (req_ncrit),
    .wdog_tmo_i (wdog), .pc_i (pc), .sw_we_i (sw_we), .sw_wdata_i (sw_wdata),
    .ret_mchk_i (ret_mchk), .ret_crit_i (ret_crit), .ret_ncrit_i (ret_ncrit),
    .sw_o (sw), .redir_vld_o (redir_vld), .redir_addr_o (redir_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: every redirect pulse must match the next queued expectation
  always @(negedge clk) begin
    if (mon_on && redir_vld === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: actual unexpected redirect 0x%0h expected none", redir_addr);
      end else begin
        chk("R2/R8 redirect address", redir_addr, exp_q.pop_front());
      end
    end
  end

  task automatic clear_in();
    {req_mchk, req_crit, req_ncrit, wdog} = '0;
    {ret_mchk, ret_crit, ret_ncrit}       = '0;
    sw_we = 1'b0; sw_wdata = '0;
  endtask

  // apply one cycle of stimulus; returns at the negedge after the sampling edge
  task automatic fire(input logic mc, input logic cr, input logic nc, input logic wd,
                      input logic rm, input logic rc, input logic rn,
                      input logic we, input logic [31:0] wdat, input logic [31:0] p);
    req_mchk = mc; req_crit = cr; req_ncrit = nc; wdog = wd;
    ret_mchk = rm; ret_crit = rc; ret_ncrit = rn;
    sw_we = we; sw_wdata = wdat; pc = p;
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    clear_in();
    pc = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R10 reset state
    chk("R10 state word after reset", sw, 32'h0);
    chk("R10 no redirect after reset", {31'b0, redir_vld}, 32'h0);

    // R3 all masked
    fire(1,1,1,1, 0,0,0, 0,0, 32'h0F00);
    chk("R3 masked requests keep state", sw, 32'h0);

    // R12 write in idle cycle
    fire(0,0,0,0, 0,0,0, 1,32'h107, 32'h0);
    chk("R12 idle write applied", sw, 32'h107);

    // R1 all pending: machine check wins, R5 clears all three
    exp_q.push_back(32'h100);
    fire(1,1,1,0, 0,0,0, 0,0, 32'h1000);
    chk("R5 mchk take clears all enables", sw, 32'h100);
    @(negedge clk);
    chk("R2 pulse lasts one cycle", {31'b0, redir_vld}, 32'h0);

    // R8 return, R4 saved values
    exp_q.push_back(32'h1000);
    fire(0,0,0,0, 1,0,0, 0,0, 32'h0);
    chk("R8 R4 state restored on mchk return", sw, 32'h107);

    // R9 second return ignored
    fire(0,0,0,0, 1,0,0, 0,0, 32'h0);
    chk("R9 return without context keeps state", sw, 32'h107);
    chk("R9 no redirect for empty return", {31'b0, redir_vld}, 32'h0);

    // R6 nesting, R7 watchdog
    exp_q.push_back(32'h300);
    fire(0,0,1,0, 0,0,0, 0,0, 32'h2000);
    chk("R5 ncrit take clears only EE", sw, 32'h106);
    exp_q.push_back(32'h200);
    fire(0,0,0,1, 0,0,0, 0,0, 32'h2040);
    chk("R7 watchdog taken as critical, clears CE EE", sw, 32'h104);
    exp_q.push_back(32'h2040);
    fire(0,0,0,0, 0,1,0, 0,0, 32'h0);
    chk("R6 crit return restores inner state", sw, 32'h106);
    exp_q.push_back(32'h2000);
    fire(0,0,0,0, 0,0,1, 0,0, 32'h0);
    chk("R6 ncrit context survives nesting", sw, 32'h107);

    // R11 return and request in the same cycle
    exp_q.push_back(32'h300);
    fire(0,0,1,0, 0,0,0, 0,0, 32'h3000);
    chk("R5 ncrit take", sw, 32'h106);
    exp_q.push_back(32'h3000);
    fire(0,1,0,0, 0,0,1, 0,0, 32'h3080);
    chk("R11 return wins the shared cycle", sw, 32'h107);
    exp_q.push_back(32'h200);
    fire(0,1,0,0, 0,0,0, 0,0, 32'h3100);
    chk("R11 held request taken next cycle", sw, 32'h104);
    exp_q.push_back(32'h3100);
    fire(0,0,0,0, 0,1,0, 0,0, 32'h0);
    chk("R8 crit return", sw, 32'h107);

    // R12 write dropped when a take happens
    exp_q.push_back(32'h300);
    fire(0,0,1,0, 0,0,0, 1,32'h0, 32'h4000);
    chk("R12 write lost to take", sw, 32'h106);
    exp_q.push_back(32'h4000);
    fire(0,0,0,0, 0,0,1, 0,0, 32'h0);
    chk("R8 ncrit return", sw, 32'h107);

    // R3 critical masked alone, R1 mchk still accepted
    fire(0,0,0,0, 0,0,0, 1,32'h105, 32'h0);
    chk("R12 write applied", sw, 32'h105);
    fire(0,1,0,0, 0,0,0, 0,0, 32'h4800);
    chk("R3 critical masked by CE", sw, 32'h105);
    exp_q.push_back(32'h100);
    fire(1,0,1,0, 0,0,0, 0,0, 32'h5000);
    chk("R1 mchk over ncrit", sw, 32'h100);
    exp_q.push_back(32'h5000);
    fire(0,0,0,0, 1,0,0, 0,0, 32'h0);
    chk("R8 mchk return", sw, 32'h105);

    // R9 empty critical return
    fire(0,0,0,0, 0,1,0, 0,0, 32'h0);
    chk("R9 crit return without context", sw, 32'h105);
    chk("R9 no redirect", {31'b0, redir_vld}, 32'h0);

    repeat (3) @(negedge clk);
    chk("R2 all expected redirects seen", exp_q.size(), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule